// File: doc/BRIEF.md
# Multi-Mode Digitally Controlled Oscillator

This block is the numeric heart of one timing path. A phase accumulator advances by a nominal step on every clock. A signed frequency-offset word is added to that step, and the accumulator produces the output clock phase together with a carry pulse each time it wraps. The offset word carries 48 fractional bits. Its least significant bit therefore stands for 2^-48 of the nominal step when the nominal step is 2^48.

A mode controller decides where the offset word comes from. In free-run the offset is zero, so the output depends only on the system clock. In locked mode the offset follows the loop-filter word derived from the selected reference. In holdover the block applies a running average of the offset that it learned while locked. In DCO mode the loop is open and an external servo writes the word through a small host port. If the reference is lost while locked, the block falls back to holdover on its own, and it returns to locked when the reference comes back.

Top module: `dco_core`

## Requirements
- R1: `mode_req` encodes 0 = free-run, 1 = locked, 2 = holdover, 3 = DCO. `mode_o` shows the applied mode with the same encoding, one clock after the request.
- R2: In free-run the phase advances by exactly `NOM_INC` per clock, and `lf_freq` has no effect.
- R3: In locked mode with `ref_valid` high, the phase advances by `NOM_INC` plus the sign-extended `lf_freq`.
- R4: A locked request while `ref_valid` is low gives holdover (`mode_o` = 2). When `ref_valid` returns high, the mode goes back to locked (`mode_o` = 1).
- R5: The holdover word is an exponential average of `lf_freq` with weight 2^-`AVG_SHIFT`. It is updated only on clocks where the applied mode is locked. After a long steady lock at value F it lies in [F-2^AVG_SHIFT+1, F]. In holdover the phase advances by `NOM_INC` plus that word, and `lf_freq` is ignored.
- R6: In DCO mode the phase advances by `NOM_INC` plus the committed host word, and `lf_freq` is ignored.
- R7: A host write with `host_addr` = 0 only stages the low `BUS_W` bits and changes nothing that is applied. A write with `host_addr` = 1 supplies the upper bits and commits the whole word in one step.
- R8: The accumulator wraps modulo 2^`ACC_W`. `carry_o` is high for exactly the clocks on which a wrap happened.
- R9: While `rst_n` is low, `phase_o` is 0, `carry_o` is 0 and `mode_o` is 0. The host word and the holdover word also start at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Accumulator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_req | input | 2 | Requested operating mode |
| ref_valid | input | 1 | Selected reference is usable |
| lf_freq | input | FW | Signed loop-filter frequency word |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 1 | 0: stage low part, 1: upper part and commit |
| host_wdata | input | BUS_W | Host write data |
| phase_o | output | ACC_W | Accumulator phase |
| carry_o | output | 1 | Pulse on accumulator wrap |
| mode_o | output | 2 | Applied mode |

## Verification
The wrap and carry properties assume that the total step, `NOM_INC` plus the offset, stays positive and below 2^`ACC_W`. The stimulus keeps every offset tiny next to a nominal step of 2^60, so each clock advances the phase by a positive amount. The mode properties assume that `mode_req` is always one of the four defined codes, which holds because the field has no spare value. Offsets are compared against phase differences taken only after the mode and offset registers have settled, so pipeline latency never enters a check.

// File: rtl/dco_pkg.sv
package dco_pkg;
   typedef enum logic [1:0] {
      MD_FREE = 2'd0,
      MD_LOCK = 2'd1,
      MD_HOLD = 2'd2,
      MD_DCO  = 2'd3
   } dco_mode_e;
endpackage

// File: rtl/dco_mode_ctrl.sv
module dco_mode_ctrl
   import dco_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic [1:0] mode_req,
   input  logic      ref_valid,
   output dco_mode_e mode_q
);
   dco_mode_e mode_d;

   always_comb begin
      case (mode_req)
         2'd1:    mode_d = ref_valid ? MD_LOCK : MD_HOLD;
         2'd2:    mode_d = MD_HOLD;
         2'd3:    mode_d = MD_DCO;
         default: mode_d = MD_FREE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= MD_FREE;
      else        mode_q <= mode_d;
   end

   // R4: lost reference under a lock request falls back to holdover
   p_auto_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_req == 2'd1 && !ref_valid) |=> mode_q == MD_HOLD);
   // R4: restored reference returns to locked
   p_restore_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_req == 2'd1 && ref_valid) |=> mode_q == MD_LOCK);
   // R1: DCO request is honoured one clock later
   p_dco_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_req == 2'd3) |=> mode_q == MD_DCO);
endmodule

// File: rtl/dco_hold_avg.sv
module dco_hold_avg #(
   parameter int FW        = 56,
   parameter int AVG_SHIFT = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 upd_en,
   input  logic signed [FW-1:0] lf_word,
   output logic signed [FW-1:0] hold_word
);
   if (AVG_SHIFT < 0 || AVG_SHIFT > 16) begin : g_bad_shift
      $error("dco_hold_avg: AVG_SHIFT must lie in 0..16");
   end

   logic signed [FW-1:0] avg_q;

   if (AVG_SHIFT == 0) begin : g_snapshot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      avg_q <= '0;
         else if (upd_en) avg_q <= lf_word;
      end
   end else begin : g_average
      logic signed [FW:0] diff;
      logic signed [FW:0] adj;
      always_comb begin
         diff = {lf_word[FW-1], lf_word} - {avg_q[FW-1], avg_q};
         adj  = diff >>> AVG_SHIFT;
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      avg_q <= '0;
         else if (upd_en) avg_q <= avg_q + adj[FW-1:0];
      end
   end

   assign hold_word = avg_q;

   // R5: history frozen whenever the applied mode is not locked
   p_hold_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_en |=> $stable(avg_q));
endmodule

// File: rtl/dco_host_reg.sv
module dco_host_reg #(
   parameter int FW    = 56,
   parameter int BUS_W = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr,
   input  logic                 addr,
   input  logic [BUS_W-1:0]     wdata,
   output logic signed [FW-1:0] host_word
);
   if (FW > 2 * BUS_W) begin : g_bad_bus
      $error("dco_host_reg: word needs more than two bus beats");
   end

   logic [FW-1:0] word_q;

   if (FW > BUS_W) begin : g_split
      localparam int HI_W = FW - BUS_W;
      logic [BUS_W-1:0] stage_lo;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stage_lo <= '0;
            word_q   <= '0;
         end else if (wr) begin
            if (!addr) stage_lo <= wdata;
            else       word_q   <= {wdata[HI_W-1:0], stage_lo};
         end
      end
   end else begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)  word_q <= '0;
         else if (wr) word_q <= wdata[FW-1:0];
      end
   end

   assign host_word = word_q;

   // R7: a low-part write never changes the committed word
   p_low_stage_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !addr && FW > BUS_W) |=> $stable(word_q));
endmodule

// File: rtl/dco_phase_acc.sv
module dco_phase_acc #(
   parameter int               ACC_W   = 64,
   parameter int               FW      = 56,
   parameter logic [ACC_W-1:0] NOM_INC = ACC_W'(1) << 48
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic signed [FW-1:0] freq_word,
   output logic [ACC_W-1:0]     phase_q,
   output logic                 carry_q
);
   localparam int EXT_W = ACC_W - FW;

   if (EXT_W < 1) begin : g_bad_acc
      $error("dco_phase_acc: ACC_W must exceed the word width");
   end

   logic [ACC_W-1:0] step;
   logic [ACC_W:0]   sum;

   always_comb begin
      step = NOM_INC + {{EXT_W{freq_word[FW-1]}}, freq_word};
      sum  = {1'b0, phase_q} + {1'b0, step};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
         carry_q <= 1'b0;
      end else begin
         phase_q <= sum[ACC_W-1:0];
         carry_q <= sum[ACC_W];
      end
   end

   // R8: a carry pulse means the phase went backwards (it wrapped)
   p_carry_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      carry_q |-> phase_q < $past(phase_q));
   // R8: no carry means the phase moved forward
   p_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !carry_q |-> phase_q >= $past(phase_q));
endmodule

// File: rtl/dco_core.sv
module dco_core
   import dco_pkg::*;
#(
   parameter int               INT_W     = 8,
   parameter int               FRAC_W    = 48,
   parameter int               ACC_W     = 64,
   parameter int               BUS_W     = 32,
   parameter int               AVG_SHIFT = 8,
   parameter logic [ACC_W-1:0] NOM_INC   = ACC_W'(1) << 48,
   localparam int              FW        = INT_W + FRAC_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       mode_req,
   input  logic             ref_valid,
   input  logic [FW-1:0]    lf_freq,
   input  logic             host_wr,
   input  logic             host_addr,
   input  logic [BUS_W-1:0] host_wdata,
   output logic [ACC_W-1:0] phase_o,
   output logic             carry_o,
   output logic [1:0]       mode_o
);
   if (FRAC_W < 48) begin : g_bad_frac
      $error("dco_core: at least 48 fractional bits are required");
   end
   if (INT_W < 1) begin : g_bad_int
      $error("dco_core: INT_W must be positive");
   end

   dco_mode_e            mode_q;
   logic signed [FW-1:0] hold_word;
   logic signed [FW-1:0] host_word;
   logic signed [FW-1:0] freq_d;
   logic signed [FW-1:0] freq_q;

   dco_mode_ctrl u_mode (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode_req (mode_req),
      .ref_valid(ref_valid),
      .mode_q   (mode_q)
   );

   dco_hold_avg #(.FW(FW), .AVG_SHIFT(AVG_SHIFT)) u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .upd_en   (mode_q == MD_LOCK),
      .lf_word  (lf_freq),
      .hold_word(hold_word)
   );

   dco_host_reg #(.FW(FW), .BUS_W(BUS_W)) u_host (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (host_wr),
      .addr     (host_addr),
      .wdata    (host_wdata),
      .host_word(host_word)
   );

   always_comb begin
      case (mode_q)
         MD_LOCK: freq_d = lf_freq;
         MD_HOLD: freq_d = hold_word;
         MD_DCO:  freq_d = host_word;
         default: freq_d = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) freq_q <= '0;
      else        freq_q <= freq_d;
   end

   dco_phase_acc #(.ACC_W(ACC_W), .FW(FW), .NOM_INC(NOM_INC)) u_acc (
      .clk      (clk),
      .rst_n    (rst_n),
      .freq_word(freq_q),
      .phase_q  (phase_o),
      .carry_q  (carry_o)
   );

   assign mode_o = mode_q;

   // R2: free-run applies a zero offset
   p_free_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mode_q == MD_FREE |=> freq_q == '0);
   // R6: DCO mode applies the committed host word
   p_dco_host_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mode_q == MD_DCO |=> freq_q == $past(host_word));
endmodule

// File: tb/dco_core_tb.sv
`timescale 1ns/1ps
module dco_core_tb;
   localparam int          FW  = 56;
   localparam logic [63:0] NOM = 64'h1000_0000_0000_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  mode_req = 2'd0;
   logic        ref_valid = 1'b0;
   logic [FW-1:0] lf_freq = '0;
   logic        host_wr = 1'b0;
   logic        host_addr = 1'b0;
   logic [31:0] host_wdata = '0;
   logic [63:0] phase_o;
   logic        carry_o;
   logic [1:0]  mode_o;

   int total = 0;
   int bad = 0;

   always #2.5 clk = ~clk;

   dco_core #(.NOM_INC(NOM)) u_dut (
      .clk(clk), .rst_n(rst_n), .mode_req(mode_req), .ref_valid(ref_valid),
      .lf_freq(lf_freq), .host_wr(host_wr), .host_addr(host_addr),
      .host_wdata(host_wdata), .phase_o(phase_o), .carry_o(carry_o),
      .mode_o(mode_o)
   );

   typedef struct packed {
      logic [1:0]           req;
      logic                 refv;
      logic signed [FW-1:0] lf;
      logic [1:0]           exp_mode;
      logic signed [FW-1:0] exp_off;
   } vec_t;

   localparam vec_t VEC [6] = '{
      '{2'd0, 1'b1,  56'sd123,  2'd0,  56'sd0},
      '{2'd1, 1'b1,  56'sd1000, 2'd1,  56'sd1000},
      '{2'd1, 1'b1, -56'sd777,  2'd1, -56'sd777},
      '{2'd3, 1'b1,  56'sd999,  2'd3, -56'sd500},
      '{2'd3, 1'b0,  56'sd42,   2'd3, -56'sd500},
      '{2'd0, 1'b0, -56'sd9,    2'd0,  56'sd0}
   };

   function automatic logic [63:0] exp_step(input logic signed [FW-1:0] off);
      return NOM + {{(64-FW){off[FW-1]}}, off};
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic settle();
      repeat (5) @(negedge clk);
   endtask

   task automatic get_step(output logic [63:0] d);
      logic [63:0] p0;
      @(negedge clk);
      p0 = phase_o;
      @(negedge clk);
      d = phase_o - p0;
   endtask

   task automatic host_write(input logic a, input logic [31:0] d);
      @(negedge clk);
      host_wr = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
   end

   initial begin
      logic [63:0] d, held;
      longint off;
      int wraps, carries;
      logic [63:0] p0;

      // R9: reset state
      repeat (3) @(negedge clk);
      chk("R9 phase in reset", phase_o, 64'd0);
      chk("R9 carry in reset", {63'd0, carry_o}, 64'd0);
      chk("R9 mode in reset", {62'd0, mode_o}, 64'd0);
      rst_n = 1'b1;
      settle();
      get_step(d);
      chk("R9 R2 free step after reset", d, NOM);

      // preset host word to -500 (R7)
      host_write(1'b0, 32'hFFFF_FE0C);
      host_write(1'b1, 32'h00FF_FFFF);

      // vector table walk: R1 R2 R3 R6
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         mode_req = VEC[i].req; ref_valid = VEC[i].refv; lf_freq = VEC[i].lf;
         settle();
         chk($sformatf("R1 mode vec%0d", i), {62'd0, mode_o}, {62'd0, VEC[i].exp_mode});
         get_step(d);
         chk($sformatf("R2 R3 R6 step vec%0d", i), d, exp_step(VEC[i].exp_off));
      end

      // R7: low-part write alone has no effect in DCO mode
      @(negedge clk); mode_req = 2'd3; ref_valid = 1'b1;
      settle();
      host_write(1'b0, 32'd1234);
      settle();
      get_step(d);
      chk("R7 staged low part not applied", d, exp_step(-56'sd500));
      host_write(1'b1, 32'd0);
      settle();
      get_step(d);
      chk("R7 commit applies full word", d, exp_step(56'sd1234));

      // R5: long lock, then loss of reference
      @(negedge clk); mode_req = 2'd1; ref_valid = 1'b1; lf_freq = 56'sd100000;
      repeat (3000) @(negedge clk);
      ref_valid = 1'b0;
      settle();
      chk("R4 auto holdover on ref loss", {62'd0, mode_o}, 64'd2);
      get_step(d);
      held = d;
      off = longint'(d - NOM);
      total++;
      if (off > 100000 || off < 100000 - 255) begin
         bad++;
         $display("FAIL R5 hold offset actual=%0d expected=99745..100000", off);
      end
      @(negedge clk); lf_freq = 56'sd5;
      settle();
      get_step(d);
      chk("R5 lf ignored in holdover", d, held);
      @(negedge clk); ref_valid = 1'b1;
      settle();
      chk("R4 return to locked", {62'd0, mode_o}, 64'd1);
      get_step(d);
      chk("R3 R4 locked step after restore", d, exp_step(56'sd5));

      // R6: lf ignored in DCO
      @(negedge clk); mode_req = 2'd3; lf_freq = -56'sd3000;
      settle();
      get_step(d);
      chk("R6 lf ignored in DCO", d, exp_step(56'sd1234));

      // R8: carry matches wraps
      @(negedge clk); mode_req = 2'd0;
      settle();
      wraps = 0; carries = 0;
      for (int k = 0; k < 40; k++) begin
         p0 = phase_o;
         @(negedge clk);
         if (phase_o < p0) wraps++;
         if (carry_o) carries++;
         chk("R8 carry vs wrap", {63'd0, carry_o}, {63'd0, phase_o < p0});
      end
      total++;
      if (carries == 0 || carries != wraps) begin
         bad++;
         $display("FAIL R8 carry count actual=%0d expected=%0d", carries, wraps);
      end

      finish_run();
   end
endmodule